// File: doc/BRIEF.md
# Four-Lane Interleaved Vector Accumulator

The block holds one vector as a running accumulator and runs three commands on it. A load command fills the accumulator from an input stream. An accumulate command combines each incoming element with the matching accumulator element and writes the result back. A store command streams the accumulator out in index order and then leaves it empty.

Elements are spread round-robin over four lanes, so element i belongs to lane i mod 4. Each lane keeps its share of the vector in a private circular FIFO and has its own arithmetic operation, which can be changed between commands. A small controller accepts one command at a time. It steps the lanes in turn as elements move on the input or output stream, and it takes no new command until every lane has processed its share.

Top module: `vec_accum_engine`

## Requirements
- R1: While reset is held and right after it is released, cmd_ready_o is 1, in_ready_o is 0 and out_valid_o is 0.
- R2: A load of N elements followed by a store of N returns the same N elements on out_data_o in their original index order.
- R3: With lane operation code 00 (or 11) an accumulate leaves acc[i] + x[i] (mod 2^W) in the accumulator.
- R4: With lane operation code 01 an accumulate leaves acc[i] - x[i] (mod 2^W).
- R5: With lane operation code 10 an accumulate leaves the low W bits of acc[i] * x[i].
- R6: Element i uses the operation in lane_op_i[2*(i mod 4)+1 : 2*(i mod 4)], so lanes with different codes work at the same time.
- R7: A store (opcode 10) empties the accumulator, so a following store of the same length returns zeros, and an empty accumulator takes part in an accumulate as zero.
- R8: After a command with opcode 00, 01 or 10 and a nonzero length is accepted, cmd_ready_o stays 0 until the command's last element has been transferred.
- R9: Opcode 11 is accepted and ignored: no element moves, cmd_ready_o is 1 again in the next cycle, and the accumulator contents are kept.
- R10: Lengths that are not a multiple of four work. Lanes whose index is below N mod 4 carry one more element than the other lanes.
- R11: Vectors of up to 4000 elements are handled.
- R12: A command with length 0 moves no element and completes within two cycles. A load of length 0 still empties the accumulator (opcode 00 first clears).
- R13: A load (opcode 00) replaces all previous accumulator contents.
- R14: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o is stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Engine idle; command taken when valid and ready |
| cmd_op_i | input | 2 | 00 load, 01 accumulate, 10 store, 11 ignored |
| cmd_len_i | input | 12 | Vector length in elements, 0 to 4000 |
| lane_op_i | input | 8 | Two bits per lane: 00 add, 01 subtract, 10 multiply, 11 add |
| in_valid_i | input | 1 | Input element valid |
| in_ready_o | output | 1 | Engine takes an input element |
| in_data_i | input | 16 | Input element |
| out_valid_o | output | 1 | Output element valid during store |
| out_ready_i | input | 1 | Sink takes the output element |
| out_data_o | output | 16 | Output element |

## Verification
The bench targets lengths of 1 to 3 mod 4. A design that split the lanes' counts wrongly would hang or emit the elements out of order. It also targets lengths of 0 and 4000. A design that mishandled 0 would never return to idle, and one that mishandled 4000 would overrun a lane FIFO and corrupt its wrap-around. Mixed per-lane operations catch a lane selecting the wrong operation or the wrong subtraction order. A store followed by a second store catches an accumulator that is not emptied. A reserved opcode wedged between a load and a store catches a design that treats it as a real command and consumes or clears data. Random output back-pressure catches data that changes while a transfer is stalled.

// File: rtl/vec_pkg.sv
package vec_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_ACC   = 2'b01,
    OP_STORE = 2'b10,
    OP_RSVD  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_MUL  = 2'b10,
    ALU_ADDX = 2'b11
  } alu_e;
endpackage

// File: rtl/vec_lane.sv
module vec_lane
  import vec_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 1000,
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  cmd_e             cmd_i,
  input  logic [CNT_W-1:0] share_i,
  input  logic             step_i,
  input  logic [W-1:0]     din_i,
  input  logic [1:0]       op_i,
  output logic [W-1:0]     head_o,
  output logic             done_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] fill_q, avail_q, rem_q;
  cmd_e             cmd_q;
  logic [W-1:0]     alu_res;
  logic             act;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign act    = step_i && (rem_q != '0);
  assign head_o = (avail_q != '0) ? mem[rd_q] : '0;  // empty reads as zero
  assign done_o = (rem_q == '0);

  always_comb begin
    case (alu_e'(op_i))
      ALU_SUB: alu_res = head_o - din_i;
      ALU_MUL: alu_res = W'(head_o * din_i);
      default: alu_res = head_o + din_i;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (act && cmd_q != OP_STORE)
      mem[wr_q] <= (cmd_q == OP_LOAD) ? din_i : alu_res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= '0;
      wr_q    <= '0;
      fill_q  <= '0;
      avail_q <= '0;
      rem_q   <= '0;
      cmd_q   <= OP_LOAD;
    end else if (start_i) begin
      rem_q <= share_i;
      cmd_q <= cmd_i;
      if (cmd_i == OP_LOAD || (cmd_i == OP_STORE && share_i == '0)) begin
        rd_q    <= '0;
        wr_q    <= '0;
        fill_q  <= '0;
        avail_q <= '0;
      end else begin
        avail_q <= fill_q;  // entries present before this command
      end
    end else if (act) begin
      rem_q <= rem_q - 1'b1;
      case (cmd_q)
        OP_LOAD: begin
          wr_q   <= nxt(wr_q);
          fill_q <= fill_q + 1'b1;
        end
        OP_ACC: begin
          wr_q <= nxt(wr_q);
          if (avail_q != '0) begin
            rd_q    <= nxt(rd_q);
            avail_q <= avail_q - 1'b1;
          end else begin
            fill_q <= fill_q + 1'b1;
          end
        end
        OP_STORE: begin
          if (rem_q == CNT_W'(1)) begin
            rd_q    <= '0;
            wr_q    <= '0;
            fill_q  <= '0;
            avail_q <= '0;
          end else if (avail_q != '0) begin
            rd_q    <= nxt(rd_q);
            avail_q <= avail_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vec_ctrl.sv
module vec_ctrl
  import vec_pkg::*;
#(
  parameter int LANES = 4,
  parameter int LEN_W = 12,
  parameter int CNT_W = 10,
  parameter int SEL_W = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_valid_i,
  output logic                        cmd_ready_o,
  input  logic [1:0]                  cmd_op_i,
  input  logic [LEN_W-1:0]            cmd_len_i,
  input  logic                        all_done_i,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic                        start_o,
  output cmd_e                        cmd_o,
  output logic [LANES-1:0][CNT_W-1:0] share_o,
  output logic [LANES-1:0]            step_o,
  output logic [SEL_W-1:0]            sel_o
);
  logic             busy_q, xfer, fire;
  cmd_e             op_q;
  logic [SEL_W-1:0] sel_q;

  assign cmd_ready_o = !busy_q;
  assign cmd_o       = cmd_e'(cmd_op_i);
  assign start_o     = cmd_valid_i && cmd_ready_o && (cmd_o != OP_RSVD);
  assign xfer        = busy_q && !all_done_i;
  assign in_ready_o  = xfer && (op_q != OP_STORE);
  assign out_valid_o = xfer && (op_q == OP_STORE);
  assign fire        = (in_ready_o && in_valid_i) || (out_valid_o && out_ready_i);
  assign sel_o       = sel_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign share_o[l] = CNT_W'(cmd_len_i / LEN_W'(LANES))
                      + CNT_W'((cmd_len_i % LEN_W'(LANES)) > LEN_W'(l));
    assign step_o[l]  = fire && (sel_q == SEL_W'(l));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_LOAD;
      sel_q  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      op_q   <= cmd_o;
      sel_q  <= '0;
    end else begin
      if (busy_q && all_done_i) busy_q <= 1'b0;
      if (fire) sel_q <= (sel_q == SEL_W'(LANES - 1)) ? '0 : sel_q + 1'b1;
    end
  end
endmodule

// File: rtl/vec_accum_engine.sv
module vec_accum_engine
  import vec_pkg::*;
#(
  parameter int W       = 16,
  parameter int LANES   = 4,
  parameter int MAX_LEN = 4000,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [1:0]         cmd_op_i,
  input  logic [LEN_W-1:0]   cmd_len_i,
  input  logic [2*LANES-1:0] lane_op_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [W-1:0]       in_data_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [W-1:0]       out_data_o
);
  localparam int DEPTH = (MAX_LEN + LANES - 1) / LANES;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic                        start;
  cmd_e                        cmd;
  logic [LANES-1:0][CNT_W-1:0] share;
  logic [LANES-1:0]            step, done;
  logic [SEL_W-1:0]            sel;
  logic [W-1:0]                head [LANES];

  vec_ctrl #(
    .LANES(LANES), .LEN_W(LEN_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_ready_o(cmd_ready_o),
    .cmd_op_i   (cmd_op_i),
    .cmd_len_i  (cmd_len_i),
    .all_done_i (&done),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .start_o    (start),
    .cmd_o      (cmd),
    .share_o    (share),
    .step_o     (step),
    .sel_o      (sel)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vec_lane #(.W(W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start),
      .cmd_i  (cmd),
      .share_i(share[l]),
      .step_i (step[l]),
      .din_i  (in_data_i),
      .op_i   (lane_op_i[2*l +: 2]),
      .head_o (head[l]),
      .done_o (done[l])
    );
  end

  assign out_data_o = head[sel];
endmodule

// File: rtl/vec_accum_engine_chk.sv
module vec_accum_engine_chk #(
  parameter int W     = 16,
  parameter int LEN_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic [1:0]       cmd_op_i,
  input logic [LEN_W-1:0] cmd_len_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [W-1:0]     out_data_o
);
  logic take;
  assign take = cmd_valid_i && cmd_ready_o;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !in_ready_o && !out_valid_o);  // R1
  AST_ONE_DIRECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));  // R2
  AST_BUSY_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && cmd_op_i != 2'b11 && cmd_len_i != '0 |=> !cmd_ready_o);  // R8
  AST_RSVD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && cmd_op_i == 2'b11 |=> cmd_ready_o && !in_ready_o && !out_valid_o);  // R9
  AST_ZERO_LEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && cmd_len_i == '0 |=> !in_ready_o && !out_valid_o);  // R12
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));  // R14
endmodule

bind vec_accum_engine vec_accum_engine_chk #(.W(W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/vec_accum_engine_bench.sv
module vec_accum_engine_bench;
  localparam int W = 16;
  localparam int MAXN = 4000;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0, cmd_ready_o;
  logic [1:0]    cmd_op_i = '0;
  logic [LW-1:0] cmd_len_i = '0;
  logic [7:0]    lane_op_i;
  logic          in_valid_i = 1'b0, in_ready_o;
  logic [W-1:0]  in_data_i = '0;
  logic          out_valid_o, out_ready_i = 1'b0;
  logic [W-1:0]  out_data_o;

  int total = 0, bad = 0, cycles = 0;
  logic [W-1:0] acc_m [MAXN];
  logic [1:0]   lop [4];

  assign lane_op_i = {lop[3], lop[2], lop[1], lop[0]};

  always #4 clk = ~clk;

  vec_accum_engine u_vec_accum_engine (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_op_i(cmd_op_i), .cmd_len_i(cmd_len_i), .lane_op_i(lane_op_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o)
  );

  function automatic logic [W-1:0] f_alu(input logic [1:0] op, input logic [W-1:0] a, b);
    case (op)
      2'b01:   return a - b;
      2'b10:   return W'(a * b);
      default: return a + b;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [1:0] op, input int len);
    @(negedge clk);
    while (!cmd_ready_o) @(negedge clk);
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    cmd_len_i   = LW'(len);
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic push(input logic [W-1:0] v);
    if ($urandom % 4 == 0) @(negedge clk);
    in_valid_i = 1'b1;
    in_data_i  = v;
    while (!in_ready_o) @(negedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic do_load(input int len);
    send_cmd(2'b00, len);
    if (len > 0) chk("R8 busy after load", {31'd0, cmd_ready_o}, 32'd0);
    for (int i = 0; i < MAXN; i++) acc_m[i] = '0;
    for (int i = 0; i < len; i++) begin
      logic [W-1:0] v = W'($urandom);
      acc_m[i] = v;
      push(v);
    end
  endtask

  task automatic do_acc(input int len);
    send_cmd(2'b01, len);
    for (int i = 0; i < len; i++) begin
      logic [W-1:0] v = W'($urandom);
      acc_m[i] = f_alu(lop[i % 4], acc_m[i], v);
      push(v);
    end
  endtask

  task automatic do_store(input int len, input bit stall, input string req);
    send_cmd(2'b10, len);
    for (int i = 0; i < len; i++) begin
      bit got = 1'b0;
      while (!got) begin
        out_ready_i = stall ? 1'($urandom % 2) : 1'b1;
        if (out_valid_o && out_ready_i) begin
          chk(req, {16'd0, out_data_o}, {16'd0, acc_m[i]});
          got = 1'b1;
          @(negedge clk);
        end else if (out_valid_o) begin
          logic [W-1:0] d = out_data_o;
          @(negedge clk);
          chk("R14 stall hold", {15'd0, out_valid_o, out_data_o}, {15'd0, 1'b1, d});
        end else begin
          @(negedge clk);
        end
      end
    end
    out_ready_i = 1'b0;
    for (int i = 0; i < MAXN; i++) acc_m[i] = '0;
  endtask

  task automatic set_ops(input logic [1:0] a, b, c, d);
    lop[0] = a; lop[1] = b; lop[2] = c; lop[3] = d;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 0);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    set_ops(2'b00, 2'b00, 2'b00, 2'b00);
    for (int i = 0; i < MAXN; i++) acc_m[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset", {29'd0, cmd_ready_o, in_ready_o, out_valid_o}, 32'b100);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {29'd0, cmd_ready_o, in_ready_o, out_valid_o}, 32'b100);

    do_load(8);  do_store(8, 1'b0, "R2 load/store order");
    do_load(7);  do_acc(7);  do_store(7, 1'b1, "R3 R10 add len 7");
    set_ops(2'b01, 2'b01, 2'b01, 2'b01);
    do_load(5);  do_acc(5);  do_store(5, 1'b1, "R4 subtract");
    set_ops(2'b10, 2'b10, 2'b10, 2'b10);
    do_load(6);  do_acc(6);  do_store(6, 1'b0, "R5 multiply");
    set_ops(2'b00, 2'b01, 2'b10, 2'b11);
    do_load(13); do_acc(13); do_acc(13); do_store(13, 1'b1, "R6 mixed lanes");

    do_load(9);  do_store(9, 1'b0, "R7 first store");
    do_store(9, 1'b0, "R7 store after store is zero");
    do_acc(9);   do_store(9, 1'b0, "R7 acc on empty");

    do_load(10); do_load(10); do_store(10, 1'b0, "R13 load replaces");

    do_load(6);
    send_cmd(2'b11, 6);
    chk("R9 reserved ignored", {30'd0, cmd_ready_o, in_ready_o}, 32'b10);
    do_store(6, 1'b0, "R9 contents kept");

    do_load(5);
    send_cmd(2'b00, 0);
    chk("R12 zero len quiet", {30'd0, in_ready_o, out_valid_o}, 32'd0);
    @(negedge clk);
    chk("R12 zero len done", {29'd0, cmd_ready_o, in_ready_o, out_valid_o}, 32'b100);
    for (int i = 0; i < MAXN; i++) acc_m[i] = '0;
    do_store(5, 1'b0, "R12 zero load empties");

    for (int n = 1; n <= 3; n++) begin
      do_load(n); do_acc(n); do_store(n, 1'b1, "R10 short vector");
    end

    set_ops(2'(($urandom)), 2'($urandom), 2'($urandom), 2'($urandom));
    do_load(MAXN); do_acc(MAXN); do_store(MAXN, 1'b1, "R11 max length");

    for (int r = 0; r < 15; r++) begin
      int n = 1 + int'($urandom % 64);
      int k = int'($urandom % 3);
      set_ops(2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
      do_load(n);
      for (int j = 0; j < k; j++) do_acc(n);
      do_store(n, 1'b1, "R6 R10 random");
    end
    finish_run();
  end
endmodule